// File: doc/BRIEF.md
# Serial Byte Sender with Completion Interrupt

This block is a minimal serial port model. It holds one data byte and a control byte. When software sets the busy bit together with the clock-source bit, a countdown starts. The countdown is driven by a tick enable input. When the countdown runs out, the whole byte is handed to a byte sink in one go rather than shifted out bit by bit. The data byte is then zeroed, the busy bit is dropped, and an interrupt request pulses for one cycle.

Software reaches the block through two write strobes that share one write-data bus, and through two read-back ports. The counter limit is a parameter, `LIMIT`, which defaults to 128. A transfer completes on the tick after the counter has reached `LIMIT`, so it takes `LIMIT + 1` counted ticks. No line-level timing and no receive path are modelled.

Top module: `serial_xfer`

## Requirements
- R1: After reset, `data_q` reads 0x00, `ctrl_q` reads 0x7E, and `out_valid` and `irq` are low.
- R2: A pulse on `wr_data` loads `wdata` into the data byte, and `data_q` shows it from the next cycle.
- R3: A transfer completes on the (`LIMIT`+1)th cycle in which `tick` is high while control bit 7 (busy) and control bit 0 (internal clock) are both 1. Cycles without `tick` do not count.
- R4: On completion, `out_valid` rises for one cycle with `out_byte` equal to the data byte as it was before completion. In the same cycle `data_q` reads 0x00 and control bit 7 reads 0, while control bit 0 keeps its value.
- R5: `irq` is high in exactly the cycle in which `out_valid` is high.
- R6: `out_valid` and `irq` never stay high for two cycles in a row.
- R7: A control write with bit 7 at 0 cancels a running transfer. No byte is emitted and no interrupt is raised for it.
- R8: While control bit 0 is 0, ticks do not advance the count, so a busy transfer never completes.
- R9: Control bits 6 to 1 always read 1, whatever was written.
- R10: Every control write restarts the count at zero. Rewriting 0x81 mid-transfer therefore requires `LIMIT`+1 fresh ticks.
- R11: If `wr_data` coincides with the completing tick, the old byte is emitted and the newly written byte remains in `data_q`.
- R12: Ticks while control bit 7 is 0 have no effect: nothing is emitted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count enable for the transfer countdown |
| wr_data | input | 1 | Write strobe for the data byte |
| wr_ctrl | input | 1 | Write strobe for the control byte |
| wdata | input | 8 | Write data shared by both strobes |
| data_q | output | 8 | Data byte read-back |
| ctrl_q | output | 8 | Control read-back: bit 7 busy, bits 6:1 fixed 1, bit 0 internal clock |
| out_valid | output | 1 | One-cycle strobe marking an emitted byte |
| out_byte | output | 8 | Emitted byte, valid with `out_valid` |
| irq | output | 1 | One-cycle completion interrupt request |

## Verification
The hardest situations to reach are those that land on the completing tick itself: a data write in that cycle, and a control rewrite after most of the count has elapsed. The stimulus reaches them by issuing exactly `LIMIT` ticks and then placing the contested access on the next tick. For the restart case, it sends another `LIMIT` ticks after the rewrite and confirms that nothing has been emitted yet. An exhaustive sweep sends all 256 byte values, with the spacing between ticks alternating, so that uncounted idle cycles are exercised as well.

// File: rtl/serial_xfer.sv
module serial_xfer #(
  parameter int LIMIT = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_data,
  input  logic       wr_ctrl,
  input  logic [7:0] wdata,
  output logic [7:0] data_q,
  output logic [7:0] ctrl_q,
  output logic       out_valid,
  output logic [7:0] out_byte,
  output logic       irq
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [7:0]    data_r;
  logic          busy_r, intclk_r;
  logic [CW-1:0] cnt_r;
  logic          run, done;

  assign run    = tick & busy_r & intclk_r;
  assign done   = run & (cnt_r == CW'(LIMIT)) & ~wr_ctrl;
  assign data_q = data_r;
  assign ctrl_q = {busy_r, 6'h3F, intclk_r};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_r    <= '0;
      busy_r    <= 1'b0;
      intclk_r  <= 1'b0;
      cnt_r     <= '0;
      out_valid <= 1'b0;
      out_byte  <= '0;
      irq       <= 1'b0;
    end else begin
      out_valid <= done;
      irq       <= done;
      if (done) out_byte <= data_r;

      if (wr_ctrl) begin
        busy_r   <= wdata[7];
        intclk_r <= wdata[0];
        cnt_r    <= '0;
      end else if (done) begin
        busy_r <= 1'b0;
        cnt_r  <= '0;
      end else if (run) begin
        cnt_r <= cnt_r + 1'b1;
      end

      if (wr_data)   data_r <= wdata;
      else if (done) data_r <= '0;
    end
  end
endmodule

module serial_xfer_chk #(
  parameter int LIMIT = 128
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       wr_data,
  input logic       wr_ctrl,
  input logic [7:0] wdata,
  input logic [7:0] data_q,
  input logic [7:0] ctrl_q,
  input logic       out_valid,
  input logic [7:0] out_byte,
  input logic       irq
);
  localparam int NW = $clog2(LIMIT + 2) + 1;
  logic [NW-1:0] n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             n <= '0;
    else if (wr_ctrl || out_valid)          n <= '0;
    else if (tick && ctrl_q[7] && ctrl_q[0]) n <= n + 1'b1;
  end

  a_r3_tick_count: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> n == NW'(LIMIT + 1));
  a_r4_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!ctrl_q[7] && (data_q == 8'h00 || $past(wr_data))));
  a_r5_irq_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> irq);
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || irq) |=> !(out_valid || irq));
  a_r7_write_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> !out_valid);
  a_r9_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[6:1] == 6'h3F);
endmodule

bind serial_xfer serial_xfer_chk #(.LIMIT(LIMIT)) u_chk (.*);

// File: tb/serial_xfer_bench.sv
module serial_xfer_bench;
  localparam int LIMIT = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, wr_data = 1'b0, wr_ctrl = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] data_q, ctrl_q, out_byte;
  logic out_valid, irq;
  int checks = 0, errors = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  serial_xfer #(.LIMIT(LIMIT)) u_serial_xfer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_data(wr_data), .wr_ctrl(wr_ctrl),
    .wdata(wdata), .data_q(data_q), .ctrl_q(ctrl_q), .out_valid(out_valid),
    .out_byte(out_byte), .irq(irq));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr_d(input logic [7:0] v);
    wr_data = 1'b1; wdata = v; cyc(); wr_data = 1'b0;
  endtask

  task automatic wr_c(input logic [7:0] v);
    wr_ctrl = 1'b1; wdata = v; cyc(); wr_ctrl = 1'b0;
  endtask

  task automatic ticks(input int n, input int gap, output int seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; cyc(); tick = 1'b0;
      if (out_valid || irq) seen++;
      for (int g = 0; g < gap; g++) begin
        cyc();
        if (out_valid || irq) seen++;
      end
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    finish_run();
  end

  initial begin
    int s;
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
    // R1
    chk(data_q == 8'h00, "R1 data", data_q, 8'h00);
    chk(ctrl_q == 8'h7E, "R1 ctrl", ctrl_q, 8'h7E);
    chk(!out_valid && !irq, "R1 outputs", {out_valid, irq}, 0);

    // R2
    wr_d(8'hC3);
    chk(data_q == 8'hC3, "R2 readback", data_q, 8'hC3);

    // R9
    wr_c(8'h00);
    chk(ctrl_q == 8'h7E, "R9 write 00", ctrl_q, 8'h7E);
    wr_c(8'h01);
    chk(ctrl_q == 8'h7F, "R9 write 01", ctrl_q, 8'h7F);

    // R12 idle ticks
    ticks(300, 0, s);
    chk(s == 0, "R12 idle ticks", s, 0);
    chk(data_q == 8'hC3, "R12 data kept", data_q, 8'hC3);

    // R8 busy with external clock
    wr_c(8'h80);
    ticks(300, 0, s);
    chk(s == 0, "R8 no count", s, 0);
    chk(ctrl_q == 8'hFE, "R8 still busy", ctrl_q, 8'hFE);

    // R7 abort then restart needs full count
    wr_c(8'h81);
    ticks(50, 0, s);
    wr_c(8'h01);
    ticks(300, 0, s);
    chk(s == 0, "R7 abort silent", s, 0);
    chk(data_q == 8'hC3, "R7 data kept", data_q, 8'hC3);
    wr_c(8'h81);
    ticks(LIMIT, 0, s);
    chk(s == 0, "R7 counter reset", s, 0);
    ticks(1, 0, s);
    chk(out_valid && out_byte == 8'hC3, "R7 restart emits", out_byte, 8'hC3);
    cyc();

    // R10 rewrite mid-transfer
    wr_d(8'h3C);
    wr_c(8'h81);
    ticks(LIMIT - 5, 0, s);
    wr_c(8'h81);
    ticks(LIMIT, 0, s);
    chk(s == 0, "R10 restarted", s, 0);
    ticks(1, 0, s);
    chk(out_valid && out_byte == 8'h3C, "R10 emits", out_byte, 8'h3C);
    cyc();

    // R11 data write on completing tick
    wr_d(8'hA5);
    wr_c(8'h81);
    ticks(LIMIT, 0, s);
    tick = 1'b1; wr_data = 1'b1; wdata = 8'h5A;
    cyc();
    tick = 1'b0; wr_data = 1'b0;
    chk(out_valid && out_byte == 8'hA5, "R11 old byte", out_byte, 8'hA5);
    chk(data_q == 8'h5A, "R11 new data", data_q, 8'h5A);
    cyc();

    // R3 R4 R5 R6 exhaustive sweep
    for (int v = 0; v < 256; v++) begin
      wr_d(8'(v));
      wr_c(8'h81);
      ticks(LIMIT, v % 2, s);
      chk(s == 0, "R3 early", s, 0);
      tick = 1'b1; cyc(); tick = 1'b0;
      chk(out_valid && out_byte == 8'(v), "R4 byte", out_byte, v);
      chk(irq, "R5 irq", irq, 1);
      chk(data_q == 8'h00, "R4 data zero", data_q, 0);
      chk(ctrl_q == 8'h7F, "R4 ctrl", ctrl_q, 8'h7F);
      cyc();
      chk(!out_valid && !irq, "R6 one cycle", {out_valid, irq}, 0);
    end

    finish_run();
  end
endmodule